// File: doc/BRIEF.md
# Parametric Pulse Playback Sequencer

This block builds IQ drive waveforms from a small on-chip dictionary of base pulse shapes. The full waveform of every gate is never stored. Each instruction names one stored shape and gives it three parameters:

- an amplitude scale;
- a time-stretch factor;
- a phase offset.

The block plays the shape out as a stream of 16-bit I/Q samples, one sample per output slot. Each slot stands for one nanosecond of envelope. As each sample is emitted it is scaled, held for the stretch factor, and rotated by the phase. One stored envelope therefore serves many gates of different strength, length and axis.

Shapes are written through a single-cycle write port before playback. Instructions arrive on a valid/ready handshake, and the sequencer accepts the next one in the final slot of the current pulse. Consecutive pulses therefore join without a gap. Scaling and rotation are done in a short registered pipeline. The rotation draws on a sine/cosine table that is computed at elaboration.

Top module: `pulse_sequencer`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid` is 0, `out_i` and `out_q` are 0, and `cmd_ready` is 1.
- R2: An accepted instruction emits exactly SHAPE_LEN·k valid samples, where k is the stretch factor. Stored samples appear in ascending sample order, and each one is repeated on k consecutive valid cycles.
- R3: Before rotation each stored component x is scaled to round((x·amp)/2^15). Rounding adds 2^14 and then shifts right arithmetically. `cmd_amp` is unsigned with 15 fraction bits, so 0x8000 is unity gain.
- R4: The output is I = round((a·C − b·S)/2^14) and Q = round((a·S + b·C)/2^14). Here (a, b) is the scaled stored (I, Q) pair, C = round(16384·cos(2π·p/256)), S = round(16384·sin(2π·p/256)), and p is `cmd_phase`. Rounding adds 2^13 and then shifts right arithmetically.
- R5: Every scaled and every rotated value is clamped to the range −32768 to 32767.
- R6: If a new instruction is valid in the final slot of the current pulse, its first sample follows the last sample of the current pulse on the very next cycle. A burst of such instructions gives one unbroken run of `out_valid`.
- R7: Whenever `out_valid` is 0, `out_i` and `out_q` are both 0.
- R8: `cmd_ready` is 1 when no pulse is playing or during the final slot of the current pulse, and 0 during every other slot of a pulse.
- R9: Writing with `wr_en` stores (`wr_i`, `wr_q`) at shape `wr_addr[ADDR_W-1:IDX_W]`, sample `wr_addr[IDX_W-1:0]`. `cmd_shape` selects which stored shape is played.
- R10: `cmd_stretch` holds the stretch factor minus one, so 0 gives a factor of 1 and 15 gives a factor of 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Shape memory write strobe |
| wr_addr | input | ADDR_W (6) | {shape index, sample index} to write |
| wr_i | input | SAMPLE_W (16) | Stored in-phase sample, signed |
| wr_q | input | SAMPLE_W (16) | Stored quadrature sample, signed |
| cmd_valid | input | 1 | Instruction present |
| cmd_ready | output | 1 | Instruction taken on this edge when valid |
| cmd_shape | input | SHP_W (2) | Shape index to play |
| cmd_amp | input | AMP_W (16) | Unsigned amplitude scale, 15 fraction bits |
| cmd_stretch | input | STRETCH_W (4) | Stretch factor minus one |
| cmd_phase | input | PHASE_W (8) | Phase index, 256 steps per turn |
| out_valid | output | 1 | Output sample valid |
| out_i | output | SAMPLE_W (16) | Rotated, scaled in-phase sample |
| out_q | output | SAMPLE_W (16) | Rotated, scaled quadrature sample |

## Verification
The case hardest to reach from the ports is the hand-off in the final slot of a pulse. The next instruction must already be waiting there, or the seamless join is never exercised. The stimulus keeps `cmd_valid` raised through whole bursts: a sweep of all sixteen stretch factors, and a sweep of all 256 phase indices. The bench then measures the span of the valid run and compares it with the sample count. Clamping is the other hard case. It needs full-scale stored samples that are amplified and rotated by 45°. A dedicated extreme-valued shape is played at maximum gain at several phases to drive it.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

  // Clamp a wide signed value to the signed range of w bits.
  function automatic logic signed [47:0] clip_w(input logic signed [47:0] v, input int w);
    logic signed [47:0] hi;
    logic signed [47:0] lo;
    hi = (48'sd1 <<< (w - 1)) - 48'sd1;
    lo = -(48'sd1 <<< (w - 1));
    if (v > hi) return hi;
    else if (v < lo) return lo;
    else return v;
  endfunction

  // Rounded fixed-point trig value for table entry k of a 2**pw table.
  function automatic int trig_q(input int k, input int pw, input int frac, input bit is_cos);
    real ang;
    real v;
    ang = 2.0 * 3.14159265358979323846 * real'(k) / real'(1 << pw);
    v = is_cos ? $cos(ang) : $sin(ang);
    v = v * real'(1 << frac);
    if (v >= 0.0) return $rtoi(v + 0.5);
    else return -$rtoi(0.5 - v);
  endfunction

endpackage

// File: rtl/pseq_issue.sv
module pseq_issue #(
  parameter int SHAPE_LEN = 16,
  parameter int SHP_W     = 2,
  parameter int AMP_W     = 16,
  parameter int STRETCH_W = 4,
  parameter int PHASE_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic [SHP_W-1:0]         cmd_shape,
  input  logic [AMP_W-1:0]         cmd_amp,
  input  logic [STRETCH_W-1:0]     cmd_stretch,
  input  logic [PHASE_W-1:0]       cmd_phase,
  output logic                     rd_vld,
  output logic [SHP_W+$clog2(SHAPE_LEN)-1:0] rd_addr,
  output logic [AMP_W-1:0]         rd_amp,
  output logic [PHASE_W-1:0]       rd_phase
);
  localparam int IDX_W = $clog2(SHAPE_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SHAPE_LEN - 1);

  logic                 busy;
  logic [SHP_W-1:0]     shp_r;
  logic [IDX_W-1:0]     idx_r;
  logic [STRETCH_W-1:0] rep_r;
  logic [STRETCH_W-1:0] st_r;
  logic [AMP_W-1:0]     amp_r;
  logic [PHASE_W-1:0]   ph_r;
  logic                 last_slot;
  logic                 take;

  assign last_slot = busy && (idx_r == LAST_IDX) && (rep_r == st_r);
  assign cmd_ready = !busy || last_slot;
  assign take      = cmd_valid && cmd_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      shp_r <= '0;
      idx_r <= '0;
      rep_r <= '0;
      st_r  <= '0;
      amp_r <= '0;
      ph_r  <= '0;
    end else if (take) begin
      busy  <= 1'b1;
      shp_r <= cmd_shape;
      idx_r <= '0;
      rep_r <= '0;
      st_r  <= cmd_stretch;
      amp_r <= cmd_amp;
      ph_r  <= cmd_phase;
    end else if (busy) begin
      if (rep_r == st_r) begin
        rep_r <= '0;
        if (idx_r == LAST_IDX) busy <= 1'b0;
        else idx_r <= idx_r + 1'b1;
      end else begin
        rep_r <= rep_r + 1'b1;
      end
    end
  end

  assign rd_vld   = busy;
  assign rd_addr  = {shp_r, idx_r};
  assign rd_amp   = amp_r;
  assign rd_phase = ph_r;

  // R8: an idle sequencer always offers to take an instruction
  assert_ready_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> cmd_ready);

  // R2: while a sample is still being repeated its address holds
  assert_hold_sample_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && rep_r != st_r) |=> (busy && $stable(idx_r) && $stable(shp_r)));

  // R6: taking an instruction in the last slot keeps playback running
  assert_no_gap_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && take) |=> busy);

  // R10: the repeat counter never passes the programmed factor
  assert_rep_bound_R10: assert property (@(posedge clk) disable iff (rst)
    busy |-> (rep_r <= st_r));

endmodule

// File: rtl/pseq_shape_mem.sv
module pseq_shape_mem #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [DATA_W-1:0]        rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/pseq_scale.sv
module pseq_scale #(
  parameter int W     = 16,
  parameter int AMP_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic [2*W-1:0]   in_pair,
  input  logic [AMP_W-1:0] amp,
  output logic             out_vld,
  output logic [2*W-1:0]   out_pair
);
  import pseq_pkg::*;

  localparam int FRAC = AMP_W - 1;
  localparam logic signed [47:0] RND = 48'sd1 <<< (FRAC - 1);
  localparam logic [AMP_W-1:0] UNITY = AMP_W'(1) << FRAC;

  for (genvar ln = 0; ln < 2; ln++) begin : g_lane
    logic signed [W-1:0]  x;
    logic signed [47:0]   xs;
    logic signed [47:0]   am;
    logic signed [47:0]   rn;
    logic signed [W-1:0]  res;

    always_comb begin
      x  = in_pair[ln*W +: W];
      xs = 48'(x);
      am = 48'(amp);
      rn = (xs * am + RND) >>> FRAC;
    end

    always_ff @(posedge clk) begin
      if (rst) res <= '0;
      else     res <= W'(clip_w(rn, W));
    end

    assign out_pair[ln*W +: W] = res;
  end

  always_ff @(posedge clk) begin
    if (rst) out_vld <= 1'b0;
    else     out_vld <= in_vld;
  end

  // R3: unity gain passes the stored pair through unchanged
  assert_unity_gain_R3: assert property (@(posedge clk) disable iff (rst)
    (in_vld && amp == UNITY) |=> (out_vld && out_pair == $past(in_pair)));

  // R3: zero gain yields a zero pair
  assert_zero_gain_R3: assert property (@(posedge clk) disable iff (rst)
    (in_vld && amp == '0) |=> (out_pair == '0));

endmodule

// File: rtl/pseq_rotate.sv
module pseq_rotate #(
  parameter int W         = 16,
  parameter int PHASE_W   = 8,
  parameter int TRIG_FRAC = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] phase_early,
  input  logic               in_vld,
  input  logic [2*W-1:0]     in_pair,
  output logic               out_valid,
  output logic [W-1:0]       out_i,
  output logic [W-1:0]       out_q
);
  import pseq_pkg::*;

  localparam int TAB = 1 << PHASE_W;
  localparam int TW  = TRIG_FRAC + 2;
  localparam logic signed [47:0] RND = 48'sd1 <<< (TRIG_FRAC - 1);

  logic signed [TW-1:0] cos_rom [TAB];
  logic signed [TW-1:0] sin_rom [TAB];

  for (genvar k = 0; k < TAB; k++) begin : g_rom
    assign cos_rom[k] = TW'(trig_q(k, PHASE_W, TRIG_FRAC, 1'b1));
    assign sin_rom[k] = TW'(trig_q(k, PHASE_W, TRIG_FRAC, 1'b0));
  end

  logic signed [TW-1:0] c_r;
  logic signed [TW-1:0] s_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      c_r <= '0;
      s_r <= '0;
    end else begin
      c_r <= cos_rom[phase_early];
      s_r <= sin_rom[phase_early];
    end
  end

  logic signed [W-1:0] a_s;
  logic signed [W-1:0] b_s;
  logic signed [47:0]  ri;
  logic signed [47:0]  rq;

  always_comb begin
    a_s = in_pair[W-1:0];
    b_s = in_pair[2*W-1:W];
    ri  = (48'(a_s) * 48'(c_r) - 48'(b_s) * 48'(s_r) + RND) >>> TRIG_FRAC;
    rq  = (48'(a_s) * 48'(s_r) + 48'(b_s) * 48'(c_r) + RND) >>> TRIG_FRAC;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= in_vld;
      out_i     <= in_vld ? W'(clip_w(ri, W)) : '0;
      out_q     <= in_vld ? W'(clip_w(rq, W)) : '0;
    end
  end

  // R7: no sample value escapes while the output is not valid
  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_i == '0 && out_q == '0));

  // R4: phase index zero leaves the scaled pair unrotated
  assert_zero_phase_R4: assert property (@(posedge clk) disable iff (rst)
    (in_vld && $past(phase_early) == '0) |=> (out_i == $past(a_s) && out_q == $past(b_s)));

endmodule

// File: rtl/pulse_sequencer.sv
module pulse_sequencer #(
  parameter int SAMPLE_W  = 16,
  parameter int AMP_W     = 16,
  parameter int N_SHAPES  = 4,
  parameter int SHAPE_LEN = 16,
  parameter int STRETCH_W = 4,
  parameter int PHASE_W   = 8,
  parameter int TRIG_FRAC = 14,
  localparam int SHP_W    = $clog2(N_SHAPES),
  localparam int IDX_W    = $clog2(SHAPE_LEN),
  localparam int ADDR_W   = SHP_W + IDX_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [SAMPLE_W-1:0]  wr_i,
  input  logic [SAMPLE_W-1:0]  wr_q,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [SHP_W-1:0]     cmd_shape,
  input  logic [AMP_W-1:0]     cmd_amp,
  input  logic [STRETCH_W-1:0] cmd_stretch,
  input  logic [PHASE_W-1:0]   cmd_phase,
  output logic                 out_valid,
  output logic [SAMPLE_W-1:0]  out_i,
  output logic [SAMPLE_W-1:0]  out_q
);
  localparam int DEPTH  = N_SHAPES * SHAPE_LEN;
  localparam int PAIR_W = 2 * SAMPLE_W;

  logic                 s0_vld;
  logic [ADDR_W-1:0]    s0_addr;
  logic [AMP_W-1:0]     s0_amp;
  logic [PHASE_W-1:0]   s0_phase;

  pseq_issue #(
    .SHAPE_LEN(SHAPE_LEN), .SHP_W(SHP_W), .AMP_W(AMP_W),
    .STRETCH_W(STRETCH_W), .PHASE_W(PHASE_W)
  ) issue_i (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_shape(cmd_shape), .cmd_amp(cmd_amp),
    .cmd_stretch(cmd_stretch), .cmd_phase(cmd_phase),
    .rd_vld(s0_vld), .rd_addr(s0_addr),
    .rd_amp(s0_amp), .rd_phase(s0_phase)
  );

  logic [PAIR_W-1:0] s1_pair;

  pseq_shape_mem #(.DEPTH(DEPTH), .DATA_W(PAIR_W)) mem_i (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data({wr_q, wr_i}),
    .rd_addr(s0_addr), .rd_data(s1_pair)
  );

  // Side-band stage aligned with the memory read latency
  logic               s1_vld;
  logic [AMP_W-1:0]   s1_amp;
  logic [PHASE_W-1:0] s1_phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld   <= 1'b0;
      s1_amp   <= '0;
      s1_phase <= '0;
    end else begin
      s1_vld   <= s0_vld;
      s1_amp   <= s0_amp;
      s1_phase <= s0_phase;
    end
  end

  logic              s2_vld;
  logic [PAIR_W-1:0] s2_pair;

  pseq_scale #(.W(SAMPLE_W), .AMP_W(AMP_W)) scale_i (
    .clk(clk), .rst(rst),
    .in_vld(s1_vld), .in_pair(s1_pair), .amp(s1_amp),
    .out_vld(s2_vld), .out_pair(s2_pair)
  );

  pseq_rotate #(.W(SAMPLE_W), .PHASE_W(PHASE_W), .TRIG_FRAC(TRIG_FRAC)) rot_i (
    .clk(clk), .rst(rst),
    .phase_early(s1_phase),
    .in_vld(s2_vld), .in_pair(s2_pair),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  // R1: the first cycle after reset shows an empty, ready block
  assert_reset_state_R1: assert property (@(posedge clk)
    $fell(rst) |-> (!out_valid && out_i == '0 && out_q == '0 && cmd_ready));

endmodule

// File: tb/pulse_sequencer_tb_top.sv
module pulse_sequencer_tb_top;
  localparam int LEN = 16;
  localparam int NSH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [15:0] wr_i = '0;
  logic [15:0] wr_q = '0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_shape = '0;
  logic [15:0] cmd_amp = '0;
  logic [3:0]  cmd_stretch = '0;
  logic [7:0]  cmd_phase = '0;
  logic        out_valid;
  logic [15:0] out_i;
  logic [15:0] out_q;

  always #5 clk = ~clk;

  pulse_sequencer dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_i(wr_i), .wr_q(wr_q), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_shape(cmd_shape), .cmd_amp(cmd_amp), .cmd_stretch(cmd_stretch),
    .cmd_phase(cmd_phase), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  int     vectors = 0;
  int     fails = 0;
  bit     finished = 1'b0;
  longint cyc = 0;
  longint first_v = -1;
  longint last_v = -1;
  int     nv = 0;

  int sh_i [NSH][LEN];
  int sh_q [NSH][LEN];

  logic signed [15:0] exp_i [$];
  logic signed [15:0] exp_q [$];
  string              exp_tag [$];

  function automatic longint clip16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint trig(int p, bit c);
    real ang;
    real v;
    ang = 2.0 * 3.14159265358979323846 * real'(p) / 256.0;
    v = (c ? $cos(ang) : $sin(ang)) * 16384.0;
    if (v >= 0.0) return longint'($rtoi(v + 0.5));
    return -longint'($rtoi(0.5 - v));
  endfunction

  function automatic longint scl(longint x, longint amp);
    return clip16((x * amp + 16384) >>> 15);
  endfunction

  task automatic check(string tag, longint act, longint exp_v);
    vectors++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  // Output monitor: compares every valid sample against the model stream
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!rst) begin
      if (out_valid) begin
        if (first_v < 0) first_v = cyc;
        last_v = cyc;
        nv++;
        if (exp_i.size() == 0) begin
          check("R2 unexpected sample", 1, 0);
        end else begin
          string t;
          logic signed [15:0] ei;
          logic signed [15:0] eq;
          ei = exp_i.pop_front();
          eq = exp_q.pop_front();
          t  = exp_tag.pop_front();
          check({t, " I"}, longint'($signed(out_i)), longint'(ei));
          check({t, " Q"}, longint'($signed(out_q)), longint'(eq));
        end
      end else begin
        check("R7 idle I", longint'(out_i), 0);
        check("R7 idle Q", longint'(out_q), 0);
      end
    end
  end

  task automatic send(int shp, int amp, int st, int ph, string tag);
    @(negedge clk);
    cmd_valid   = 1'b1;
    cmd_shape   = 2'(shp);
    cmd_amp     = 16'(amp);
    cmd_stretch = 4'(st);
    cmd_phase   = 8'(ph);
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    for (int n = 0; n < LEN; n++) begin
      longint a, b, ci, si, ei, eq;
      a  = scl(sh_i[shp][n], amp);
      b  = scl(sh_q[shp][n], amp);
      ci = trig(ph, 1'b1);
      si = trig(ph, 1'b0);
      ei = clip16((a * ci - b * si + 8192) >>> 14);
      eq = clip16((a * si + b * ci + 8192) >>> 14);
      for (int r = 0; r <= st; r++) begin
        exp_i.push_back(16'(ei));
        exp_q.push_back(16'(eq));
        exp_tag.push_back(tag);
      end
    end
  endtask

  task automatic idle_cmd();
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_i.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic burst_clear();
    first_v = -1;
    last_v  = -1;
    nv      = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R2 watchdog expired, actual pending=%0d expected=0", exp_i.size());
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    // Shape contents: ramps, alternating and full-scale extremes
    for (int n = 0; n < LEN; n++) begin
      sh_i[0][n] = n * 2000 - 15000;
      sh_q[0][n] = 7000 - n * 900;
      sh_i[1][n] = -n * 1500;
      sh_q[1][n] = n * 1111;
      sh_i[2][n] = (n % 2 == 0) ? 20000 : -20000;
      sh_q[2][n] = (n % 3 == 0) ? -12345 : 9876;
      sh_i[3][n] = (n % 2 == 0) ? 32767 : -32768;
      sh_q[3][n] = (n % 3 == 0) ? -32768 : 32767;
    end

    repeat (3) @(negedge clk);
    // R1: outputs and handshake while reset is held
    check("R1 valid in reset", longint'(out_valid), 0);
    check("R1 out_i in reset", longint'(out_i), 0);
    check("R1 out_q in reset", longint'(out_q), 0);
    check("R1 ready in reset", longint'(cmd_ready), 1);
    rst = 1'b0;

    // R9: load every shape through the write port
    for (int s = 0; s < NSH; s++) begin
      for (int n = 0; n < LEN; n++) begin
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 6'((s << 4) | n);
        wr_i    = 16'(sh_i[s][n]);
        wr_q    = 16'(sh_q[s][n]);
      end
    end
    @(negedge clk);
    wr_en = 1'b0;
    check("R1 ready after reset", longint'(cmd_ready), 1);

    // R2 R10 R9: every stretch factor, unity gain, back to back
    burst_clear();
    for (int st = 0; st < 16; st++) send(st % NSH, 32768, st, 0, "R2 R10 R9 stretch");
    idle_cmd();
    drain();
    check("R6 stretch burst count", nv, 2176);
    check("R6 stretch burst span", last_v - first_v + 1, 2176);

    // R4: full phase sweep, back to back
    burst_clear();
    for (int p = 0; p < 256; p++) send(p % 3, 24576, 0, p, "R4 phase");
    idle_cmd();
    drain();
    check("R6 phase burst count", nv, 4096);
    check("R6 phase burst span", last_v - first_v + 1, 4096);

    // R3: amplitude sweep including zero, unity and maximum gain
    for (int k = 0; k < 16; k++) send(k % NSH, k * 4369, k % 3, k * 16, "R3 amplitude");
    send(0, 32768, 1, 0, "R3 unity");
    send(1, 1, 0, 64, "R3 tiny");
    idle_cmd();
    drain();

    // R5: full-scale samples at maximum gain and diagonal phases
    for (int p = 0; p < 256; p += 32) send(3, 65535, 0, p, "R5 saturation");
    send(2, 65535, 0, 96, "R5 saturation");
    idle_cmd();
    drain();

    // R8: ready drops mid-pulse and returns once playback ends
    send(0, 32768, 3, 0, "R8 pulse");
    idle_cmd();
    check("R8 ready mid pulse", longint'(cmd_ready), 0);
    drain();
    check("R8 ready after pulse", longint'(cmd_ready), 1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule